// File: doc/BRIEF.md
# Bidirectional Edge Counter with Capture

This block is a sixteen-bit event counter driven by an external signal rather than by the system clock. One of two input pins is chosen as the count source. The chosen signal passes through a two-flop synchroniser, and every change of its level, rising or falling, moves the count one step. A direction pin sets whether that step is an increment or a decrement.

The count returns to zero on any of three requests: a hardware clear pin, a software clear strobe, or a clear request from an output-event scheduler. Software can load any value at any time through a write port. A capture strobe copies the live count into a separate register. Three one-clock interrupt pulses report a capture, a step across the full-range wrap point, and a step across the mid-range point. Each pulse has its own enable.

Top module: `edge_counter16`

## Requirements
- R1: While `rst_n` is low, `count` and `cap_value` are 0x0000 and all three interrupt outputs are low.
- R2: Each rising or falling transition of the selected source changes `count` by exactly one step. The new value appears on the third rising clock edge after the input changes.
- R3: When `src_sel` is 0 the source is `src_a`, and when `src_sel` is 1 the source is `src_b`. Transitions on the other pin leave `count` unchanged.
- R4: When `dir_down` is 0 a step adds one, and when `dir_down` is 1 a step subtracts one, modulo 2^16.
- R5: If any of `hw_clr`, `sw_clr` or `sched_clr` is high at a clock edge, `count` becomes 0x0000 at that edge. This overrides a write and a count step in the same cycle.
- R6: If `wr_en` is high at a clock edge and no clear is requested, `count` takes `wr_data` at that edge. A count step falling on the same edge is discarded.
- R7: If `cap_trig` is high at a clock edge, `cap_value` takes the value `count` held before that edge. `irq_cap` is high for the following cycle when `cap_ie` is 1.
- R8: A count step from 0xFFFF up to 0x0000, or from 0x0000 down to 0xFFFF, raises `irq_wrap` for one cycle when `wrap_ie` is 1. The pulse comes in the same cycle the new count is shown.
- R9: A count step from 0x7FFF up to 0x8000, or from 0x8000 down to 0x7FFF, raises `irq_half` for one cycle when `half_ie` is 1. The pulse comes in the same cycle the new count is shown.
- R10: A write or clear that lands on a boundary value raises no interrupt. No interrupt pulse is raised while its enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_a | input | 1 | Count source 0, asynchronous |
| src_b | input | 1 | Count source 1, asynchronous |
| src_sel | input | 1 | Source select (0 = src_a, 1 = src_b) |
| dir_down | input | 1 | Direction (0 = up, 1 = down) |
| hw_clr | input | 1 | Hardware clear pin |
| sw_clr | input | 1 | Software clear strobe |
| sched_clr | input | 1 | Clear request from the event scheduler |
| cap_trig | input | 1 | Capture strobe |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 16 | Value to load into the count |
| wrap_ie | input | 1 | Enable for irq_wrap |
| half_ie | input | 1 | Enable for irq_half |
| cap_ie | input | 1 | Enable for irq_cap |
| count | output | 16 | Current count |
| cap_value | output | 16 | Last captured count |
| irq_wrap | output | 1 | Full-range crossing pulse |
| irq_half | output | 1 | Mid-range crossing pulse |
| irq_cap | output | 1 | Capture pulse |

## Verification
Rising and falling transitions are driven one after another in both directions. This shows whether the detector catches both edges and whether the direction pin sets the sign of the step. Directed walks across 0xFFFF/0x0000 and 0x7FFF/0x8000 in each direction are compared with the same values reached by a write, with an enable low, and with a step that is not a crossing. Together these separate true crossing detection from a plain comparison on the value. Writes and clears are placed exactly on the cycle where an edge takes effect, which exposes the priority order. Toggling the unused pin shows that the select works. A seeded random mix of steps, writes, captures and clears is then checked against a bench model.

// File: rtl/edge_counter16.sv
module edge_counter16 #(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         src_a,
  input  logic         src_b,
  input  logic         src_sel,
  input  logic         dir_down,
  input  logic         hw_clr,
  input  logic         sw_clr,
  input  logic         sched_clr,
  input  logic         cap_trig,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         wrap_ie,
  input  logic         half_ie,
  input  logic         cap_ie,
  output logic [W-1:0] count,
  output logic [W-1:0] cap_value,
  output logic         irq_wrap,
  output logic         irq_half,
  output logic         irq_cap
);
  localparam logic [W-1:0] ALL_ONES = '1;
  localparam logic [W-1:0] MID_LO   = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MID_HI   = {1'b1, {(W-1){1'b0}}};

  logic [SYNC:0] sh;
  logic          step, clr, adv, wrap_x, half_x;
  logic [W-1:0]  nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC-1:0], (src_sel ? src_b : src_a)};

  assign step   = sh[SYNC-1] ^ sh[SYNC];
  assign clr    = hw_clr | sw_clr | sched_clr;
  assign adv    = step & ~clr & ~wr_en;
  assign nxt    = dir_down ? count - 1'b1 : count + 1'b1;
  assign wrap_x = adv & (dir_down ? (count == '0) : (count == ALL_ONES));
  assign half_x = adv & (dir_down ? (count == MID_HI) : (count == MID_LO));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count     <= '0;
      cap_value <= '0;
      irq_wrap  <= 1'b0;
      irq_half  <= 1'b0;
      irq_cap   <= 1'b0;
    end else begin
      if (clr)        count <= '0;
      else if (wr_en) count <= wr_data;
      else if (step)  count <= nxt;
      if (cap_trig)   cap_value <= count;
      irq_wrap <= wrap_ie & wrap_x;
      irq_half <= half_ie & half_x;
      irq_cap  <= cap_ie & cap_trig;
    end
endmodule

module edge_counter16_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         step,
  input logic         dir_down,
  input logic         hw_clr,
  input logic         sw_clr,
  input logic         sched_clr,
  input logic         cap_trig,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic         wrap_ie,
  input logic         half_ie,
  input logic         cap_ie,
  input logic [W-1:0] count,
  input logic [W-1:0] cap_value,
  input logic         irq_wrap,
  input logic         irq_half,
  input logic         irq_cap
);
  localparam logic [W-1:0] ALL_ONES = '1;
  localparam logic [W-1:0] MID_LO   = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MID_HI   = {1'b1, {(W-1){1'b0}}};

  always_comb
    if (!rst_n) assert_reset_state_R1: assert (count == '0 && cap_value == '0);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_en && !hw_clr && !sw_clr && !sched_clr) |=> $stable(count));

  assert_step_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && !hw_clr && !sw_clr && !sched_clr) |=>
      (count == ($past(dir_down) ? $past(count) - 1'b1 : $past(count) + 1'b1)));

  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_clr || sw_clr || sched_clr) |=> (count == '0));

  assert_write_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hw_clr && !sw_clr && !sched_clr) |=> (count == $past(wr_data)));

  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_trig |=> (cap_value == $past(count)));

  assert_wrap_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wrap |-> (count == '0 || count == ALL_ONES));

  assert_half_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_half |-> (count == MID_LO || count == MID_HI));

  assert_no_gated_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_ie && !half_ie && !cap_ie) |=> (!irq_wrap && !irq_half && !irq_cap));

  assert_no_irq_on_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || hw_clr || sw_clr || sched_clr) |=> (!irq_wrap && !irq_half));
endmodule

bind edge_counter16 edge_counter16_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .dir_down(dir_down),
  .hw_clr(hw_clr), .sw_clr(sw_clr), .sched_clr(sched_clr),
  .cap_trig(cap_trig), .wr_en(wr_en), .wr_data(wr_data),
  .wrap_ie(wrap_ie), .half_ie(half_ie), .cap_ie(cap_ie),
  .count(count), .cap_value(cap_value),
  .irq_wrap(irq_wrap), .irq_half(irq_half), .irq_cap(irq_cap)
);

// File: tb/sim_edge_counter16.sv
`timescale 1ns/1ps
module sim_edge_counter16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_a = 0, src_b = 0, src_sel = 0, dir_down = 0;
  logic hw_clr = 0, sw_clr = 0, sched_clr = 0, cap_trig = 0, wr_en = 0;
  logic [15:0] wr_data = '0;
  logic wrap_ie = 1, half_ie = 1, cap_ie = 1;
  logic [15:0] count, cap_value;
  logic irq_wrap, irq_half, irq_cap;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] mc = '0;

  always #10 clk = ~clk;

  edge_counter16 u0 (
    .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b), .src_sel(src_sel),
    .dir_down(dir_down), .hw_clr(hw_clr), .sw_clr(sw_clr), .sched_clr(sched_clr),
    .cap_trig(cap_trig), .wr_en(wr_en), .wr_data(wr_data),
    .wrap_ie(wrap_ie), .half_ie(half_ie), .cap_ie(cap_ie),
    .count(count), .cap_value(cap_value),
    .irq_wrap(irq_wrap), .irq_half(irq_half), .irq_cap(irq_cap)
  );

  function automatic logic [15:0] f_next(input logic [15:0] c, input logic dn);
    return dn ? c - 16'd1 : c + 16'd1;
  endfunction
  function automatic logic f_wrap(input logic [15:0] c, input logic dn);
    return dn ? (c == 16'h0000) : (c == 16'hFFFF);
  endfunction
  function automatic logic f_half(input logic [15:0] c, input logic dn);
    return dn ? (c == 16'h8000) : (c == 16'h7FFF);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic flip_selected();
    if (src_sel) src_b = ~src_b; else src_a = ~src_a;
  endtask

  task automatic step_chk(input string tag, input logic dn);
    logic ew, eh;
    ew = wrap_ie & f_wrap(mc, dn);
    eh = half_ie & f_half(mc, dn);
    dir_down = dn;
    flip_selected();
    repeat (3) @(negedge clk);
    mc = f_next(mc, dn);
    chk({tag, " count"}, count, mc);
    chk({tag, " irq_wrap"}, {15'd0, irq_wrap}, {15'd0, ew});
    chk({tag, " irq_half"}, {15'd0, irq_half}, {15'd0, eh});
    @(negedge clk);
  endtask

  task automatic load(input string tag, input logic [15:0] v);
    wr_en = 1; wr_data = v;
    @(negedge clk);
    wr_en = 0;
    mc = v;
    chk({tag, " count"}, count, mc);
    chk({tag, " no irq"}, {14'd0, irq_wrap, irq_half}, 16'd0);
  endtask

  task automatic capture(input string tag);
    cap_trig = 1;
    @(negedge clk);
    cap_trig = 0;
    chk({tag, " cap_value"}, cap_value, mc);
    chk({tag, " irq_cap"}, {15'd0, irq_cap}, {15'd0, cap_ie});
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk("R1 reset count", count, 16'h0000);
    chk("R1 reset cap", cap_value, 16'h0000);
    chk("R1 reset irqs", {13'd0, irq_wrap, irq_half, irq_cap}, 16'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 5; i++) step_chk("R2 R4 up", 1'b0);
    for (int i = 0; i < 2; i++) step_chk("R4 down", 1'b1);

    load("R6 write", 16'hFFFE);
    step_chk("R8 to FFFF", 1'b0);
    step_chk("R8 up wrap", 1'b0);
    step_chk("R8 down wrap", 1'b1);
    load("R9 write", 16'h7FFF);
    step_chk("R9 up half", 1'b0);
    step_chk("R9 down half", 1'b1);

    wrap_ie = 0; half_ie = 0;
    load("R10 write", 16'hFFFF);
    step_chk("R10 wrap gated", 1'b0);
    load("R10 write", 16'h8000);
    step_chk("R10 half gated", 1'b1);
    wrap_ie = 1; half_ie = 1;
    load("R10 write to FFFF", 16'hFFFF);
    load("R10 write to 8000", 16'h8000);

    load("R7 write", 16'h1234);
    capture("R7 capture");
    cap_ie = 0;
    load("R7 write", 16'h4321);
    capture("R7 capture gated");
    cap_ie = 1;

    hw_clr = 1; @(negedge clk); hw_clr = 0; mc = 0;
    chk("R5 hw clear", count, 16'h0000);
    load("R5 write", 16'h00AA);
    sw_clr = 1; @(negedge clk); sw_clr = 0; mc = 0;
    chk("R5 sw clear", count, 16'h0000);
    load("R5 write", 16'h00BB);
    sched_clr = 1; @(negedge clk); sched_clr = 0; mc = 0;
    chk("R5 sched clear", count, 16'h0000);
    load("R5 write", 16'h00CC);
    sw_clr = 1; wr_en = 1; wr_data = 16'h5555;
    @(negedge clk); sw_clr = 0; wr_en = 0; mc = 0;
    chk("R5 clear beats write", count, 16'h0000);

    load("R6 write", 16'h0100);
    dir_down = 0; flip_selected();
    repeat (2) @(negedge clk);
    wr_en = 1; wr_data = 16'h0ABC;
    @(negedge clk); wr_en = 0; mc = 16'h0ABC;
    chk("R6 write beats edge", count, mc);
    repeat (3) @(negedge clk);
    chk("R6 edge discarded", count, mc);

    load("R5 write", 16'hFFFF);
    flip_selected();
    repeat (2) @(negedge clk);
    sched_clr = 1;
    @(negedge clk); sched_clr = 0; mc = 0;
    chk("R5 clear beats edge", count, 16'h0000);
    chk("R10 no wrap on clear", {15'd0, irq_wrap}, 16'd0);
    repeat (3) @(negedge clk);

    src_b = ~src_b;
    repeat (4) @(negedge clk);
    chk("R3 src_b ignored", count, mc);
    src_b = src_a;
    repeat (4) @(negedge clk);
    src_sel = 1;
    repeat (4) @(negedge clk);
    chk("R3 switch no step", count, mc);
    step_chk("R3 src_b counts", 1'b0);
    src_a = ~src_a;
    repeat (4) @(negedge clk);
    chk("R3 src_a ignored", count, mc);

    for (int i = 0; i < 300; i++) begin
      int unsigned r;
      r = $urandom % 10;
      if (r < 6) step_chk("R2 random step", logic'($urandom % 2));
      else if (r == 6) load("R6 random write", ((i % 4) == 0) ? 16'h7FFE + 16'($urandom % 4) : 16'($urandom));
      else if (r == 7) load("R6 random edge", ($urandom % 2) ? 16'hFFFF : 16'h0000);
      else if (r == 8) capture("R7 random capture");
      else begin
        sw_clr = 1; @(negedge clk); sw_clr = 0; mc = 0;
        chk("R5 random clear", count, 16'h0000);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule